// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block sits behind a serial-peripheral front end that has already assembled whole bytes. It takes each received byte together with the level of the active-low select line. It decodes the opcode and collects the address and data bytes. It then runs the instruction against a small internal byte array and a status and protection register. Commands that read stream their results back one byte per received byte. Commands that change state act only when select returns high after a complete frame.

The array is a parameterised number of bytes, with erasable sectors and blocks whose sizes are set by parameters. Program and erase operations are self-timed. Each kind of operation holds a busy flag for its own parameterised number of clock cycles. Programming ANDs new data into the stored byte, so a program can clear bits but never set them. Multi-byte sequential programming runs through short follow-on frames, and it stops by itself at the top of the array or at the edge of a protected region.

Top module: `serial_flash_seq`

## Requirements
- R1: After reset, busy and tx_en are 0 and the status byte reads 0x0C. Status bit 0 is busy, bit 1 is write enable, bits 3:2 are the protection level, bit 6 is sequential-program mode and bit 7 is the lock bit.
- R2: Opcode 03h followed by three address bytes (most significant first; only the low AW bits are used) presents mem[addr] after the third address byte. Each later byte presents the next address, and the address wraps from the top of the array to 0.
- R3: Opcode 0Bh behaves like 03h, except that one dummy byte follows the address and the first data appears after that dummy byte.
- R4: Opcode 90h or ABh with three address bytes outputs BFh for A0=0 and 48h for A0=1. Each later byte swaps to the other value.
- R5: Opcode 05h outputs the current status byte after every received byte. While busy is 1, every frame with another opcode is ignored completely.
- R6: Opcode 06h sets write enable and 04h clears both write enable and sequential-program mode. A state-changing command acts only on the rise of cs_n after all of its bytes, and a short frame has no effect. tx_en is 0 once the frame has ended.
- R7: Opcode 02h with three address bytes and one data byte requires write enable. It writes mem & data, holds busy for T_PROG cycles, and clears write enable when it completes.
- R8: Opcode 20h sets to FFh the 2^SECT_W-byte sector that holds the address, with busy held for T_SECT cycles. Opcode 52h or D8h does the same for a 2^BLK_W-byte block over T_BLK cycles. Opcode 60h or C7h erases the whole array over T_CHIP cycles. All three require write enable and clear it when they complete.
- R9: Protection level 1 locks the top quarter of the array, level 2 the top half and level 3 all of it. A program or erase aimed at a locked address is ignored. A chip erase runs only at level 0.
- R10: Opcode 01h with one data byte loads bit 7 and bits 3:2 of that byte into status, but only when the frame just before it was a 50h frame. Otherwise it is ignored.
- R11: While wp_n is 0 and the lock bit is 1, a 01h frame is ignored.
- R12: Opcode AFh with three address bytes and one data byte (write enable required) programs that byte and enters sequential-program mode. In this mode an AFh-plus-data frame programs the next address. In this mode only AFh, 04h and 05h are accepted.
- R13: When sequential programming writes the top address, or an address whose successor is locked, the mode ends and write enable is cleared once the busy period finishes. The address does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low frame select, held low for a whole frame |
| wp_n | input | 1 | Active-low hardware lock enable for the status write |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte, opcode first |
| tx_en | output | 1 | tx_byte holds the next byte to send |
| tx_byte | output | 8 | Next outgoing byte |
| busy | output | 1 | A program or erase is in progress |

## Verification
On every cycle the assertions check four things: the output is quiet while the block is deselected, a busy period starts only at the end of a frame, the protection and lock bits cannot change during a busy period, and write enable stays set during a busy period and while sequential-program mode is active. The bench's scenarios are the only way to show the data behaviour: the read and ID streams, address wrap, the bitwise AND of programming, the exact erase ranges, the rules of the paired status write and the hardware lock, and the way sequential programming stops at the top of the array or below a locked region.

// File: rtl/serial_flash_seq.sv
module serial_flash_seq #(
  parameter int AW     = 10,
  parameter int SECT_W = 6,
  parameter int BLK_W  = 8,
  parameter int T_PROG = 40,
  parameter int T_SECT = 800,
  parameter int T_BLK  = 1600,
  parameter int T_CHIP = 4000,
  parameter logic [7:0] MFR_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'h48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       wp_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       tx_en,
  output logic [7:0] tx_byte,
  output logic       busy
);
  localparam int DEPTH = 1 << AW;
  localparam int TM1 = (T_PROG > T_SECT) ? T_PROG : T_SECT;
  localparam int TM2 = (T_BLK > T_CHIP) ? T_BLK : T_CHIP;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int TW = $clog2(TMAX + 1);

  localparam logic [7:0] C_RD = 8'h03, C_FRD = 8'h0B, C_SE = 8'h20, C_BE1 = 8'h52,
    C_BE2 = 8'hD8, C_CE1 = 8'h60, C_CE2 = 8'hC7, C_PP = 8'h02, C_SEQ = 8'hAF,
    C_STAT = 8'h05, C_ARM = 8'h50, C_WST = 8'h01, C_WEN = 8'h06, C_WDIS = 8'h04,
    C_ID1 = 8'h90, C_ID2 = 8'hAB;

  logic [7:0]    mem [DEPTH];
  logic          cs_q, dead, idsel, wel_q, aai_q, bpl_q, arm, fin_exit;
  logic [2:0]    cnt;
  logic [7:0]    op, b1, b4;
  logic [AW-1:0] adr, rptr, aai_ptr;
  logic [1:0]    bp_q;
  logic [TW-1:0] tmr;

  logic          pg, er, aai_go, nx_exit;
  logic [AW-1:0] w_a, er_m;
  logic [7:0]    w_d;
  logic [TW-1:0] tval;

  function automatic logic locked(input logic [1:0] lvl, input logic [AW-1:0] a);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return &a[AW-1:AW-2];
      2'd2:    return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  wire [AW-1:0] adr_nx = AW'({adr, rx_byte});
  wire [7:0] status = {bpl_q, aai_q, 2'b00, bp_q, wel_q, busy};
  wire frame_end = cs_n && !cs_q;
  wire take = rx_valid && !cs_n;
  wire legal = !aai_q || op == C_SEQ || op == C_WDIS || op == C_STAT;
  wire exec = frame_end && cnt != 3'd0 && !dead && legal;
  assign busy = tmr != '0;

  always_comb begin
    pg = 1'b0; er = 1'b0; aai_go = 1'b0;
    w_a = adr; w_d = b4; er_m = '0; tval = '0;
    if (exec && wel_q) begin
      case (op)
        C_PP: begin
          tval = TW'(T_PROG);
          pg = cnt >= 3'd5 && !locked(bp_q, adr);
        end
        C_SEQ: begin
          tval = TW'(T_PROG);
          if (aai_q) begin
            w_a = aai_ptr + AW'(1);
            w_d = b1;
            pg = cnt >= 3'd2 && !locked(bp_q, w_a);
          end else begin
            pg = cnt >= 3'd5 && !locked(bp_q, adr);
            aai_go = pg;
          end
        end
        C_SE: begin
          tval = TW'(T_SECT);
          er_m = ~AW'((1 << SECT_W) - 1);
          er = cnt >= 3'd4 && !locked(bp_q, adr & er_m);
        end
        C_BE1, C_BE2: begin
          tval = TW'(T_BLK);
          er_m = ~AW'((1 << BLK_W) - 1);
          er = cnt >= 3'd4 && !locked(bp_q, adr & er_m);
        end
        C_CE1, C_CE2: begin
          tval = TW'(T_CHIP);
          er = bp_q == 2'd0;
        end
        default: ;
      endcase
    end
    nx_exit = (w_a == '1) || locked(bp_q, w_a + AW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (pg) begin
      mem[w_a] <= mem[w_a] & w_d;
    end else if (er) begin
      for (int i = 0; i < DEPTH; i++)
        if (((AW'(i) ^ adr) & er_m) == '0) mem[i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b1; cnt <= '0; op <= '0; dead <= 1'b0; adr <= '0;
      b1 <= '0; b4 <= '0; rptr <= '0; idsel <= 1'b0;
      tx_en <= 1'b0; tx_byte <= '0;
      wel_q <= 1'b0; aai_q <= 1'b0; bp_q <= 2'b11; bpl_q <= 1'b0;
      arm <= 1'b0; tmr <= '0; fin_exit <= 1'b0; aai_ptr <= '0;
    end else begin
      cs_q <= cs_n;
      if (busy) begin
        tmr <= tmr - TW'(1);
        if (tmr == TW'(1) && (!aai_q || fin_exit)) begin
          wel_q <= 1'b0;
          aai_q <= 1'b0;
        end
      end
      if (frame_end) begin
        cnt <= '0; dead <= 1'b0; tx_en <= 1'b0;
        if (cnt != 3'd0) arm <= exec && op == C_ARM;
        if (exec) begin
          case (op)
            C_WEN:  wel_q <= 1'b1;
            C_WDIS: begin wel_q <= 1'b0; aai_q <= 1'b0; end
            C_WST: if (cnt >= 3'd2 && arm && (wp_n || !bpl_q)) begin
              bpl_q <= b1[7];
              bp_q  <= b1[3:2];
            end
            default: ;
          endcase
        end
        if (pg || er) begin
          tmr <= tval;
          fin_exit <= nx_exit;
        end
        if (pg) aai_ptr <= w_a;
        if (aai_go) aai_q <= 1'b1;
      end else if (take) begin
        if (cnt != 3'd7) cnt <= cnt + 3'd1;
        if (cnt == 3'd0) begin
          op <= rx_byte;
          dead <= busy && rx_byte != C_STAT;
          if (rx_byte == C_STAT) begin
            tx_en <= 1'b1;
            tx_byte <= status;
          end
        end else if (!dead) begin
          if (cnt <= 3'd3) adr <= adr_nx;
          if (cnt == 3'd1) b1 <= rx_byte;
          if (cnt == 3'd4) b4 <= rx_byte;
          case (op)
            C_STAT: tx_byte <= status;
            C_RD: if (cnt == 3'd3) begin
              tx_en <= 1'b1;
              tx_byte <= mem[adr_nx];
              rptr <= adr_nx + AW'(1);
            end else if (cnt > 3'd3) begin
              tx_byte <= mem[rptr];
              rptr <= rptr + AW'(1);
            end
            C_FRD: if (cnt == 3'd4) begin
              tx_en <= 1'b1;
              tx_byte <= mem[adr];
              rptr <= adr + AW'(1);
            end else if (cnt > 3'd4) begin
              tx_byte <= mem[rptr];
              rptr <= rptr + AW'(1);
            end
            C_ID1, C_ID2: if (cnt == 3'd3) begin
              tx_en <= 1'b1;
              tx_byte <= rx_byte[0] ? DEV_ID : MFR_ID;
              idsel <= ~rx_byte[0];
            end else if (cnt > 3'd3) begin
              tx_byte <= idsel ? DEV_ID : MFR_ID;
              idsel <= ~idsel;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module serial_flash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       tx_en,
  input logic       busy,
  input logic       wel_q,
  input logic       aai_q,
  input logic [1:0] bp_q,
  input logic       bpl_q
);
  a_r6_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |-> !tx_en);
  a_r7_busy_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_n));
  a_r5_prot_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({bpl_q, bp_q}));
  a_r8_wel_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel_q);
  a_r13_seq_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    aai_q |-> wel_q);
endmodule

bind serial_flash_seq serial_flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .tx_en(tx_en), .busy(busy),
  .wel_q(wel_q), .aai_q(aai_q), .bp_q(bp_q), .bpl_q(bpl_q));

// File: tb/test_serial_flash_seq.sv
module test_serial_flash_seq;
  localparam int CLK_P = 10;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int SW = 6, BW = 8;
  localparam int TP = 6, TS = 10, TB = 14, TC = 20;

  logic clk = 0, rst_n = 0, cs_n = 1, wp_n = 1, rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic tx_en, busy;
  logic [7:0] tx_byte;

  always #(CLK_P/2) clk = ~clk;

  serial_flash_seq #(.AW(AW), .SECT_W(SW), .BLK_W(BW), .T_PROG(TP), .T_SECT(TS),
    .T_BLK(TB), .T_CHIP(TC)) i_serial_flash_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_en(tx_en), .tx_byte(tx_byte), .busy(busy));

  int total = 0, bad = 0;
  string ctx = "R1";
  bit finished = 0;

  logic [7:0] m_mem [DEPTH];
  int m_tmr = 0, m_aptr = 0;
  bit m_wel = 0, m_aai = 0, m_bpl = 0, m_arm = 0, m_exit = 0, m_dead = 0;
  logic [1:0] m_bp = 2'b11;
  logic [7:0] q[$];
  logic [7:0] fr[$];

  function automatic bit mprot(int a);
    case (m_bp)
      2'd0: return 0;
      2'd1: return a >= DEPTH*3/4;
      2'd2: return a >= DEPTH/2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] mstat();
    return {m_bpl, m_aai, 2'b00, m_bp, m_wel, m_tmr != 0};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", ctx, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (m_tmr > 0) begin
      m_tmr--;
      if (m_tmr == 0 && (!m_aai || m_exit)) begin m_wel = 0; m_aai = 0; end
    end
  end

  always @(negedge clk) if (rst_n && !finished) chk(busy, m_tmr != 0, "busy");

  task automatic sb(input logic [7:0] b);
    bit en; logic [7:0] v; int n, a;
    @(negedge clk);
    if (q.size() == 0) m_dead = (m_tmr != 0) && b != 8'h05;
    q.push_back(b);
    n = q.size() - 1; en = 0; v = 0; a = 0;
    if (n >= 3) a = {q[1], q[2], q[3]} % DEPTH;
    if (!m_dead) case (q[0])
      8'h05: begin en = 1; v = mstat(); end
      8'h03: if (n >= 3) begin en = 1; v = m_mem[(a + n - 3) % DEPTH]; end
      8'h0B: if (n >= 4) begin en = 1; v = m_mem[(a + n - 4) % DEPTH]; end
      8'h90, 8'hAB: if (n >= 3) begin
        en = 1; v = (q[3][0] ^ ((n - 3) % 2 == 1)) ? 8'h48 : 8'hBF;
      end
      default: ;
    endcase
    rx_valid = 1; rx_byte = b;
    @(posedge clk); #1;
    rx_valid = 0;
    chk(tx_en, en, "tx_en");
    if (en) chk(tx_byte, v, "tx_byte");
  endtask

  task automatic run();
    int n, a, pa, tv, lo, hi; bit legal, pg, er, go, wst; logic [7:0] op, d;
    @(negedge clk); cs_n = 0; q.delete();
    foreach (fr[i]) sb(fr[i]);
    @(negedge clk); cs_n = 1;
    n = q.size(); op = (n > 0) ? q[0] : 8'h00;
    a = (n >= 4) ? ({q[1], q[2], q[3]} % DEPTH) : 0;
    legal = n > 0 && !m_dead && (!m_aai || op == 8'hAF || op == 8'h04 || op == 8'h05);
    pg = 0; er = 0; go = 0; pa = a; d = (n >= 5) ? q[4] : 8'h00; tv = 0; lo = 0; hi = -1;
    if (legal && m_wel) case (op)
      8'h02: begin pg = n >= 5 && !mprot(a); tv = TP; end
      8'hAF: begin
        tv = TP;
        if (m_aai) begin pa = m_aptr + 1; d = (n >= 2) ? q[1] : 8'h00; pg = n >= 2 && !mprot(pa); end
        else begin pg = n >= 5 && !mprot(a); go = pg; end
      end
      8'h20: begin lo = a / (1 << SW) * (1 << SW); hi = lo + (1 << SW) - 1; er = n >= 4 && !mprot(lo); tv = TS; end
      8'h52, 8'hD8: begin lo = a / (1 << BW) * (1 << BW); hi = lo + (1 << BW) - 1; er = n >= 4 && !mprot(lo); tv = TB; end
      8'h60, 8'hC7: begin lo = 0; hi = DEPTH - 1; er = m_bp == 0; tv = TC; end
      default: ;
    endcase
    wst = legal && op == 8'h01 && n >= 2 && m_arm && (wp_n || !m_bpl);
    @(posedge clk); #1;
    if (n > 0) m_arm = legal && op == 8'h50;
    if (legal && op == 8'h06) m_wel = 1;
    if (legal && op == 8'h04) begin m_wel = 0; m_aai = 0; end
    if (wst) begin m_bpl = q[1][7]; m_bp = q[1][3:2]; end
    if (pg) begin
      m_mem[pa] = m_mem[pa] & d;
      m_exit = (pa == DEPTH - 1) || mprot(pa + 1);
      m_aptr = pa;
    end
    if (er) begin
      for (int i = lo; i <= hi; i++) m_mem[i] = 8'hFF;
      m_exit = 0;
    end
    if (go) m_aai = 1;
    if (pg || er) m_tmr = tv;
    chk(tx_en, 0, "tx_en after frame");
  endtask

  task automatic idle();
    while (m_tmr != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic rd(input int a, input int len);
    fr = '{8'h03, 8'h00, 8'(a >> 8), 8'(a)};
    for (int i = 0; i < len; i++) fr.push_back(8'h00);
    run();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    ctx = "R1"; chk(tx_en, 0, "reset tx_en"); chk(busy, 0, "reset busy");
    fr = '{8'h05, 8'h00, 8'h00}; run();
    chk(mstat(), 8'h0C, "model reset status");

    ctx = "R10"; fr = '{8'h01, 8'h00}; run();
    fr = '{8'h05, 8'h00}; run();
    fr = '{8'h50}; run(); fr = '{8'h01, 8'h00}; run();
    fr = '{8'h05, 8'h00}; run();
    fr = '{8'h50}; run(); fr = '{8'h06}; run(); fr = '{8'h01, 8'h0C}; run();
    fr = '{8'h05, 8'h00}; run();

    ctx = "R7"; fr = '{8'h04}; run();
    fr = '{8'h02, 8'h00, 8'h00, 8'h10, 8'h00}; run(); idle(); rd(16, 2);
    ctx = "R6"; fr = '{8'h06}; run(); fr = '{8'h02, 8'h00, 8'h00}; run();
    fr = '{8'h05, 8'h00}; run();
    ctx = "R7"; fr = '{8'h02, 8'h00, 8'h00, 8'h10, 8'hA5}; run();
    ctx = "R5"; fr = '{8'h05, 8'h00, 8'h00, 8'h00}; run();
    fr = '{8'h03, 8'h00, 8'h00, 8'h10, 8'h00}; run();
    fr = '{8'h06}; run(); idle();
    fr = '{8'h05, 8'h00}; run();
    ctx = "R7"; fr = '{8'h06}; run(); fr = '{8'h02, 8'h00, 8'h00, 8'h10, 8'h0F}; run(); idle();
    rd(16, 2);
    fr = '{8'h06}; run(); fr = '{8'h02, 8'h00, 8'h03, 8'hFF, 8'h12}; run(); idle();
    fr = '{8'h06}; run(); fr = '{8'h02, 8'h00, 8'h00, 8'h00, 8'h34}; run(); idle();

    ctx = "R2"; rd(DEPTH - 2, 5); rd(15, 3);
    ctx = "R3"; fr = '{8'h0B, 8'hFF, 8'h03, 8'hFE, 8'h77, 8'h00, 8'h00, 8'h00}; run();
    ctx = "R4"; fr = '{8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; run();
    fr = '{8'hAB, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00}; run();

    ctx = "R8";
    fr = '{8'h06}; run(); fr = '{8'h02, 8'h00, 8'h00, 8'h40, 8'h55}; run(); idle();
    fr = '{8'h06}; run(); fr = '{8'h02, 8'h00, 8'h02, 8'h00, 8'h66}; run(); idle();
    fr = '{8'h06}; run(); fr = '{8'h02, 8'h00, 8'h01, 8'hFF, 8'h11}; run(); idle();
    fr = '{8'h06}; run(); fr = '{8'h20, 8'h00, 8'h00, 8'h22}; run(); idle();
    rd(15, 3); rd(63, 2);
    fr = '{8'h06}; run(); fr = '{8'hD8, 8'h00, 8'h01, 8'h80}; run(); idle();
    rd(255, 2); rd(511, 2);

    ctx = "R9";
    fr = '{8'h50}; run(); fr = '{8'h01, 8'h04}; run();
    fr = '{8'h06}; run(); fr = '{8'h02, 8'h00, 8'h03, 8'h00, 8'h00}; run(); idle();
    fr = '{8'h06}; run(); fr = '{8'h02, 8'h00, 8'h02, 8'hFF, 8'h3C}; run(); idle();
    fr = '{8'h06}; run(); fr = '{8'h20, 8'h00, 8'h03, 8'hFF}; run(); idle();
    fr = '{8'h60}; run(); idle();
    fr = '{8'h04}; run(); rd(DEPTH - 258, 4); rd(DEPTH - 2, 2);

    ctx = "R11"; wp_n = 0;
    fr = '{8'h50}; run(); fr = '{8'h01, 8'h84}; run();
    fr = '{8'h50}; run(); fr = '{8'h01, 8'h00}; run();
    fr = '{8'h05, 8'h00}; run();
    wp_n = 1; fr = '{8'h50}; run(); fr = '{8'h01, 8'h04}; run();
    fr = '{8'h05, 8'h00}; run();

    ctx = "R12";
    fr = '{8'h06}; run(); fr = '{8'hAF, 8'h00, 8'h00, 8'h80, 8'hC3}; run();
    fr = '{8'h05, 8'h00, 8'h00}; run(); idle();
    fr = '{8'h06}; run(); fr = '{8'h05, 8'h00}; run();
    fr = '{8'hAF, 8'h81}; run(); idle();
    fr = '{8'hAF, 8'h82}; run(); idle();
    fr = '{8'h04}; run(); fr = '{8'h05, 8'h00}; run();
    rd(127, 5);

    ctx = "R13";
    fr = '{8'h06}; run(); fr = '{8'hAF, 8'h00, 8'h02, 8'hFD, 8'hF1}; run(); idle();
    fr = '{8'hAF, 8'hF2}; run(); idle();
    fr = '{8'hAF, 8'hF3}; run(); idle();
    fr = '{8'h05, 8'h00}; run();
    fr = '{8'hAF, 8'hF4}; run(); idle();
    rd(DEPTH/2 + DEPTH/4 - 4, 5);
    fr = '{8'h50}; run(); fr = '{8'h01, 8'h00}; run();
    fr = '{8'h06}; run(); fr = '{8'hC7}; run(); idle();
    fr = '{8'h06}; run(); fr = '{8'hAF, 8'h00, 8'h03, 8'hFE, 8'h5A}; run(); idle();
    fr = '{8'hAF, 8'hA5}; run(); idle();
    fr = '{8'h05, 8'h00}; run();
    fr = '{8'hAF, 8'h00}; run(); idle();
    rd(DEPTH - 2, 3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule